// File: doc/BRIEF.md
# Segmented Address Translation Unit

The unit turns a segment selector and an offset into a flat address. It has two ways of doing this, chosen for each request. The legacy mode shifts the segment value left by four bits and adds a 16-bit offset, with no checks at all. The protected mode uses the selector as an index into a small on-chip table of segment descriptors. It checks the access against the chosen descriptor and then adds the offset to the descriptor's base.

Each descriptor holds a base, a limit (the highest offset that may be used), a present flag, readable, writable and executable permissions, and a width control that chooses a 16-bit or a 32-bit offset. Software fills the table through a write port that takes an index, the data and a write enable. A failed check gives a typed fault code in place of an address. Shrinking the limit of a code segment therefore stops instruction fetches from the region above it. The result is registered and appears one cycle after the request. In protected mode the sum is truncated to 32 bits, so it is a linear address that later paging can consume.

Top module: `seg_xlate`

## Requirements
- R1: With req_mode=0 (legacy), rsp_addr is req_sel*16 plus req_off[15:0], zero-extended to 32 bits. The fault code is 0 whatever the table holds, and req_off[31:16] is ignored.
- R2: With req_mode=1 (protected), req_sel[2:0] picks one of 8 descriptors and req_sel[15:3] is ignored. When every check passes, rsp_addr is (base + effective offset) mod 2^32 and the fault code is 0.
- R3: Descriptor attribute bit 4 (wide) set makes the effective offset the full 32-bit req_off. With the bit clear, the effective offset is req_off[15:0] and the upper bits are ignored.
- R4: In protected mode, a present descriptor with effective offset greater than its limit gives fault code 2 (bounds). A fetch (req_kind=2) beyond the limit is refused in the same way.
- R5: In protected mode, a descriptor whose attribute bit 0 (present) is clear gives fault code 1 (absent). This fault takes priority over the bounds and permission checks.
- R6: In protected mode, an access that passes the bounds check still faults with code 3 (access) if the access lacks its permission. A read (req_kind=0 or 3) needs attribute bit 1 (readable), a write (req_kind=1) needs bit 2 (writable) and a fetch (req_kind=2) needs bit 3 (executable).
- R7: rsp_valid is high exactly in the cycle after a cycle with req_valid high. A faulting response carries rsp_addr=0. When rsp_valid is low, rsp_addr and rsp_fault are 0.
- R8: A table write with tbl_we high replaces all fields of entry tbl_idx at the clock edge. A request made in the same cycle as the write sees the old contents, and a request made in any later cycle sees the new contents.
- R9: After reset every descriptor is absent and rsp_valid is low.
- R10: req_mode is sampled with each request. Back-to-back requests in different modes are each translated in their own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| tbl_we | input | 1 | Descriptor table write enable |
| tbl_idx | input | 3 | Entry to write |
| tbl_base | input | 32 | Base for the written entry |
| tbl_limit | input | 32 | Limit (highest legal offset) for the written entry |
| tbl_attr | input | 5 | Attributes: bit0 present, bit1 readable, bit2 writable, bit3 executable, bit4 wide |
| req_valid | input | 1 | Translation request |
| req_mode | input | 1 | 0 legacy shift-and-add, 1 protected descriptor lookup |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| req_sel | input | 16 | Segment value or selector |
| req_off | input | 32 | Offset within the segment |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_addr | output | 32 | Translated address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 absent, 2 bounds, 3 access |

## Verification
The checker watches the request-to-response timing, the zero address that goes with every fault, the idle outputs and the legacy-mode arithmetic, which it rebuilds from the ports. It does this on every cycle. Protected-mode results depend on the table contents, which the ports cannot show. The bench therefore covers them with a sweep of all 32 attribute combinations across all eight entries, three access kinds and offsets on both sides of each limit. It also has separate scenarios for the fault priorities, the ignored selector and offset bits, address wrap, a write that coincides with a request, and back-to-back requests that change mode.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef struct packed {
    logic wide;
    logic exec;
    logic writ;
    logic read;
    logic pres;
  } seg_attr_t;

  localparam int ATTR_W = $bits(seg_attr_t);

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_READ2 = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_BOUNDS = 2'd2,
    FLT_ACCESS = 2'd3
  } flt_e;

endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import seg_xlate_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int BASE_W   = 32,
  parameter int LIM_W    = 32,
  localparam int IDX_W   = $clog2(NUM_DESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [LIM_W-1:0]  wr_limit,
  input  seg_attr_t         wr_attr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BASE_W-1:0] rd_base,
  output logic [LIM_W-1:0]  rd_limit,
  output seg_attr_t         rd_attr
);
  logic [BASE_W-1:0] base_all  [NUM_DESC];
  logic [LIM_W-1:0]  limit_all [NUM_DESC];
  seg_attr_t         attr_all  [NUM_DESC];

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_entry
    logic              hit;
    logic [BASE_W-1:0] base_r;
    logic [LIM_W-1:0]  limit_r;
    seg_attr_t         attr_r;

    assign hit = wr_en && (wr_idx == IDX_W'(g));

    // attributes carry the present flag, so they are reset
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   attr_r <= '0;
      else if (hit) attr_r <= wr_attr;
    end

    // base and limit are plain storage guarded by the write enable
    always_ff @(posedge clk) begin
      if (hit) begin
        base_r  <= wr_base;
        limit_r <= wr_limit;
      end
    end

    assign base_all[g]  = base_r;
    assign limit_all[g] = limit_r;
    assign attr_all[g]  = attr_r;
  end

  assign rd_base  = base_all[rd_idx];
  assign rd_limit = limit_all[rd_idx];
  assign rd_attr  = attr_all[rd_idx];
endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc
  import seg_xlate_pkg::*;
#(
  parameter int SEL_W      = 16,
  parameter int OFS_W      = 32,
  parameter int ADDR_W     = 32,
  parameter int LIM_W      = 32,
  parameter int NARROW_W   = 16,
  parameter int SEG_SHIFT  = 4
) (
  input  logic              prot,
  input  acc_kind_e         kind,
  input  logic [SEL_W-1:0]  sel,
  input  logic [OFS_W-1:0]  off,
  input  logic [ADDR_W-1:0] d_base,
  input  logic [LIM_W-1:0]  d_limit,
  input  seg_attr_t         d_attr,
  output logic [ADDR_W-1:0] addr,
  output flt_e              fault
);
  logic [OFS_W-1:0]  narrow_off;
  logic [OFS_W-1:0]  eff_off;
  logic [ADDR_W-1:0] legacy_sum;
  logic [ADDR_W-1:0] prot_sum;
  logic              over_limit;
  logic              perm_miss;

  assign narrow_off = OFS_W'(off[NARROW_W-1:0]);
  assign eff_off    = d_attr.wide ? off : narrow_off;
  assign legacy_sum = (ADDR_W'(sel) << SEG_SHIFT) + ADDR_W'(off[NARROW_W-1:0]);
  assign prot_sum   = d_base + ADDR_W'(eff_off);
  assign over_limit = (LIM_W'(eff_off) > d_limit);

  always_comb begin
    unique case (kind)
      ACC_WRITE: perm_miss = !d_attr.writ;
      ACC_FETCH: perm_miss = !d_attr.exec;
      default:   perm_miss = !d_attr.read;
    endcase
  end

  always_comb begin
    fault = FLT_NONE;
    addr  = legacy_sum;
    if (prot) begin
      if (!d_attr.pres)    fault = FLT_ABSENT;
      else if (over_limit) fault = FLT_BOUNDS;
      else if (perm_miss)  fault = FLT_ACCESS;
      addr = (fault == FLT_NONE) ? prot_sum : '0;
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int SEL_W    = 16,
  parameter int OFS_W    = 32,
  parameter int ADDR_W   = 32,
  localparam int IDX_W   = $clog2(NUM_DESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [OFS_W-1:0]  tbl_limit,
  input  logic [4:0]        tbl_attr,
  input  logic              req_valid,
  input  logic              req_mode,
  input  logic [1:0]        req_kind,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [OFS_W-1:0]  req_off,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [1:0]        rsp_fault
);
  logic              rst_sync_n;
  logic [ADDR_W-1:0] d_base;
  logic [OFS_W-1:0]  d_limit;
  seg_attr_t         d_attr;
  logic [ADDR_W-1:0] calc_addr;
  flt_e              calc_fault;

  logic              valid_d, valid_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  flt_e              fault_d, fault_q;

  seg_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  seg_desc_table #(
    .NUM_DESC (NUM_DESC),
    .BASE_W   (ADDR_W),
    .LIM_W    (OFS_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (tbl_we),
    .wr_idx   (tbl_idx),
    .wr_base  (tbl_base),
    .wr_limit (tbl_limit),
    .wr_attr  (seg_attr_t'(tbl_attr)),
    .rd_idx   (req_sel[IDX_W-1:0]),
    .rd_base  (d_base),
    .rd_limit (d_limit),
    .rd_attr  (d_attr)
  );

  seg_addr_calc #(
    .SEL_W  (SEL_W),
    .OFS_W  (OFS_W),
    .ADDR_W (ADDR_W),
    .LIM_W  (OFS_W)
  ) u_calc (
    .prot    (req_mode),
    .kind    (acc_kind_e'(req_kind)),
    .sel     (req_sel),
    .off     (req_off),
    .d_base  (d_base),
    .d_limit (d_limit),
    .d_attr  (d_attr),
    .addr    (calc_addr),
    .fault   (calc_fault)
  );

  // next state of the response stage
  always_comb begin
    valid_d = req_valid;
    addr_d  = req_valid ? calc_addr : '0;
    fault_d = req_valid ? calc_fault : FLT_NONE;
  end

  // response register
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      fault_q <= FLT_NONE;
    end else begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
      fault_q <= fault_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_addr  = addr_q;
  assign rsp_fault = fault_q;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEL_W  = 16,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_mode,
  input logic [SEL_W-1:0]  req_sel,
  input logic [15:0]       req_off_lo,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic [1:0]        rsp_fault
);
  logic [ADDR_W-1:0] legacy_ref;
  assign legacy_ref = (ADDR_W'(req_sel) << 4) + ADDR_W'(req_off_lo);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_addr == '0 && rsp_fault == 2'd0)); // R7

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> rsp_addr == '0); // R7

  AST_LEGACY_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_mode) |=> rsp_fault == 2'd0); // R1

  AST_LEGACY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_mode) |=> rsp_addr == $past(legacy_ref)); // R1
endmodule

bind seg_xlate seg_xlate_chk #(
  .SEL_W  (SEL_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_valid  (req_valid),
  .req_mode   (req_mode),
  .req_sel    (req_sel),
  .req_off_lo (req_off[15:0]),
  .rsp_valid  (rsp_valid),
  .rsp_addr   (rsp_addr),
  .rsp_fault  (rsp_fault)
);

// File: tb/seg_xlate_bench.sv
`timescale 1ns/1ps
module seg_xlate_bench;
  logic        clk;
  logic        rst_n;
  logic        tbl_we;
  logic [2:0]  tbl_idx;
  logic [31:0] tbl_base;
  logic [31:0] tbl_limit;
  logic [4:0]  tbl_attr;
  logic        req_valid;
  logic        req_mode;
  logic [1:0]  req_kind;
  logic [15:0] req_sel;
  logic [31:0] req_off;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic [1:0]  rsp_fault;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_base  [8];
  logic [31:0] m_limit [8];
  logic [4:0]  m_attr  [8];

  seg_xlate u_seg_xlate (
    .clk(clk), .rst_n(rst_n),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_base(tbl_base),
    .tbl_limit(tbl_limit), .tbl_attr(tbl_attr),
    .req_valid(req_valid), .req_mode(req_mode), .req_kind(req_kind),
    .req_sel(req_sel), .req_off(req_off),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // expected result from the requirements
  task automatic model(input logic mode, input logic [1:0] kind, input logic [15:0] sel,
                       input logic [31:0] off, output logic [31:0] ea, output logic [1:0] ef);
    logic [2:0]  i;
    logic [31:0] eo;
    logic        miss;
    i = sel[2:0];
    ef = 2'd0;
    if (!mode) begin
      ea = ({16'h0, sel} << 4) + {16'h0, off[15:0]};
    end else begin
      eo = m_attr[i][4] ? off : {16'h0, off[15:0]};
      case (kind)
        2'd1:    miss = !m_attr[i][2];
        2'd2:    miss = !m_attr[i][3];
        default: miss = !m_attr[i][1];
      endcase
      if (!m_attr[i][0])       ef = 2'd1;
      else if (eo > m_limit[i]) ef = 2'd2;
      else if (miss)           ef = 2'd3;
      ea = (ef == 2'd0) ? m_base[i] + eo : 32'h0;
    end
  endtask

  task automatic wr_desc(input logic [2:0] i, input logic [31:0] b, input logic [31:0] l,
                         input logic [4:0] a);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = i; tbl_base = b; tbl_limit = l; tbl_attr = a;
    @(negedge clk);
    tbl_we = 1'b0;
    m_base[i] = b; m_limit[i] = l; m_attr[i] = a;
  endtask

  task automatic do_req(input logic mode, input logic [1:0] kind, input logic [15:0] sel,
                        input logic [31:0] off, output logic v, output logic [31:0] a,
                        output logic [1:0] f);
    @(negedge clk);
    req_valid = 1'b1; req_mode = mode; req_kind = kind; req_sel = sel; req_off = off;
    @(negedge clk);
    req_valid = 1'b0;
    v = rsp_valid; a = rsp_addr; f = rsp_fault;
  endtask

  task automatic req_check(input string tag, input logic mode, input logic [1:0] kind,
                           input logic [15:0] sel, input logic [31:0] off);
    logic v; logic [31:0] a; logic [1:0] f;
    logic [31:0] ea; logic [1:0] ef;
    model(mode, kind, sel, off, ea, ef);
    do_req(mode, kind, sel, off, v, a, f);
    chk({tag, " valid"}, {31'h0, v}, 32'h1);
    chk({tag, " addr"}, a, ea);
    chk({tag, " fault"}, {30'h0, f}, {30'h0, ef});
  endtask

  function automatic string tag_of(input logic [1:0] ef);
    case (ef)
      2'd1:    return "R5 absent";
      2'd2:    return "R4 bounds";
      2'd3:    return "R6 access";
      default: return "R2/R3 pass";
    endcase
  endfunction

  initial begin
    logic v; logic [31:0] a; logic [1:0] f;
    logic [31:0] ea; logic [1:0] ef;
    logic [31:0] offs [5];

    rst_n = 1'b0; tbl_we = 1'b0; tbl_idx = '0; tbl_base = '0; tbl_limit = '0; tbl_attr = '0;
    req_valid = 1'b0; req_mode = 1'b0; req_kind = '0; req_sel = '0; req_off = '0;
    for (int i = 0; i < 8; i++) begin
      m_base[i] = '0; m_limit[i] = '0; m_attr[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: reset state
    chk("R9 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
    chk("R9 rsp_addr after reset", rsp_addr, 32'h0);
    for (int i = 0; i < 8; i++) begin
      do_req(1'b1, 2'd0, 16'(i), 32'h0, v, a, f);
      chk("R9 entry absent after reset", {30'h0, f}, 32'h1);
    end

    // R1: legacy sweep, table all absent, high offset bits varied
    for (int s = 0; s < 16; s++) begin
      for (int o = 0; o < 8; o++) begin
        req_check("R1 legacy", 1'b0, 2'(o), 16'(s * 16'h1111),
                  {16'(o * 16'h3779), 16'(o * 16'h2492 + 16'(s))});
      end
    end
    req_check("R1 legacy max", 1'b0, 2'd2, 16'hFFFF, 32'hFFFF_FFFF);

    // R7: idle cycle after a response
    @(negedge clk);
    chk("R7 no response when idle", {31'h0, rsp_valid}, 32'h0);
    chk("R7 idle addr zero", rsp_addr, 32'h0);
    chk("R7 idle fault zero", {30'h0, rsp_fault}, 32'h0);

    // R2..R6: sweep every attribute combination across all entries
    for (int at = 0; at < 32; at++) begin
      for (int i = 0; i < 8; i++) begin
        wr_desc(3'(i), 32'h0100_0000 * i + 32'h450 * i + 32'(at),
                (i == 7) ? 32'hFFFF_FFFF : ((32'h1 << (4 * i + 3)) - 1),
                5'(at) ^ 5'(i));
      end
      for (int i = 0; i < 8; i++) begin
        offs[0] = 32'h0;
        offs[1] = m_limit[i];
        offs[2] = m_limit[i] + 1;
        offs[3] = 32'hABCD_0005;
        offs[4] = 32'hFFFF_FFFF;
        for (int k = 0; k < 3; k++) begin
          for (int o = 0; o < 5; o++) begin
            logic [15:0] sel;
            sel = {13'(at * 37 + k * 11 + o), 3'(i)};
            model(1'b1, 2'(k), sel, offs[o], ea, ef);
            req_check(tag_of(ef), 1'b1, 2'(k), sel, offs[o]);
          end
        end
      end
    end

    // R3: narrow offset drops upper bits, wide keeps them
    wr_desc(3'd1, 32'h0002_0000, 32'h0000_0020, 5'b00011);
    do_req(1'b1, 2'd0, 16'd1, 32'h0001_0010, v, a, f);
    chk("R3 narrow offset addr", a, 32'h0002_0010);
    chk("R3 narrow offset fault", {30'h0, f}, 32'h0);
    wr_desc(3'd1, 32'h0002_0000, 32'h0000_0020, 5'b10011);
    do_req(1'b1, 2'd0, 16'd1, 32'h0001_0010, v, a, f);
    chk("R3 wide offset exceeds limit", {30'h0, f}, 32'h2);

    // R4: shrinking a code limit blocks fetch above it
    wr_desc(3'd4, 32'h0010_0000, 32'h0000_0FFF, 5'b11011);
    do_req(1'b1, 2'd2, 16'd4, 32'h0000_0FFF, v, a, f);
    chk("R4 fetch at limit", a, 32'h0010_0FFF);
    do_req(1'b1, 2'd2, 16'd4, 32'h0000_1000, v, a, f);
    chk("R4 fetch above limit refused", {30'h0, f}, 32'h2);

    // R5/R6 priorities: absent beats bounds, bounds beats access
    wr_desc(3'd5, 32'h0, 32'h10, 5'b10000);
    do_req(1'b1, 2'd1, 16'd5, 32'h100, v, a, f);
    chk("R5 absent before bounds", {30'h0, f}, 32'h1);
    wr_desc(3'd5, 32'h0, 32'h10, 5'b10001);
    do_req(1'b1, 2'd1, 16'd5, 32'h100, v, a, f);
    chk("R6 bounds before access", {30'h0, f}, 32'h2);
    do_req(1'b1, 2'd1, 16'd5, 32'h8, v, a, f);
    chk("R6 write to read-only", {30'h0, f}, 32'h3);
    chk("R7 faulting addr zero", a, 32'h0);

    // R2: wrap modulo 2^32 and ignored selector bits
    wr_desc(3'd7, 32'hFFFF_F000, 32'hFFFF_FFFF, 5'b11111);
    do_req(1'b1, 2'd1, 16'hFFFF, 32'h0000_2000, v, a, f);
    chk("R2 wrapped sum", a, 32'h0000_1000);

    // R8: write and request in the same cycle
    wr_desc(3'd2, 32'h0000_4000, 32'h0000_00FF, 5'b10011);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 3'd2; tbl_base = 32'h0000_8000; tbl_limit = 32'hFF; tbl_attr = 5'b10011;
    req_valid = 1'b1; req_mode = 1'b1; req_kind = 2'd0; req_sel = 16'd2; req_off = 32'h10;
    @(negedge clk);
    tbl_we = 1'b0; req_valid = 1'b0;
    chk("R8 same-cycle request sees old", rsp_addr, 32'h0000_4010);
    m_base[2] = 32'h0000_8000;
    do_req(1'b1, 2'd0, 16'd2, 32'h10, v, a, f);
    chk("R8 later request sees new", a, 32'h0000_8010);

    // R10: back-to-back requests in alternating modes
    @(negedge clk);
    req_valid = 1'b1; req_mode = 1'b0; req_kind = 2'd0; req_sel = 16'd2; req_off = 32'h10;
    @(negedge clk);
    req_mode = 1'b1;
    chk("R10 first request legacy", rsp_addr, 32'h0000_0030);
    @(negedge clk);
    req_mode = 1'b0; req_sel = 16'd5;
    chk("R10 second request protected", rsp_addr, 32'h0000_8010);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 third request legacy", rsp_addr, 32'h0000_0060);
    chk("R10 third request no fault", {30'h0, rsp_fault}, 32'h0);
    @(negedge clk);
    chk("R7 valid drops after burst", {31'h0, rsp_valid}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule